// File: doc/BRIEF.md
# Float-to-Integer Converter with Selectable Overflow Policy

This unit turns one binary32 or binary64 operand into a 32-bit or 64-bit integer, signed or unsigned. A three-bit mode picks the rounding source and how values that cannot be represented are treated. Two saturating policies differ only in what a NaN becomes. A wrapping policy reduces the rounded value modulo the destination range. Each operation also yields a four-bit condition field, an overflow flag with its summary copy, and an illegal-mode indication.

Operations enter on a valid/ready input and leave on a valid/ready output. An operation is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its result appears on the outputs from the next edge onward. The result holds steady, and `in_ready` stays low, for as long as `out_valid` is high and `out_ready` is low. A new operation is accepted on the same edge that the old result drains. The input-side fields only need to be valid while `in_valid` is high.

Top module: `fcvt_int_unit`

## Requirements
- R1: Mode codes: 000 and 001 saturate with NaN giving the destination minimum; 010 and 011 saturate with NaN giving 0; 100 and 101 wrap.
- R2: Even mode codes round with `rnd` (00 nearest-even, 01 toward zero, 10 toward +infinity, 11 toward -infinity). Odd mode codes always round toward zero.
- R3: In both saturating policies, a value whose rounded result is above the destination maximum (including +infinity) gives that maximum. A value below the minimum (including -infinity) gives the minimum, which is 0 for unsigned destinations. Any other value gives the rounded integer.
- R4: In the wrapping policy, NaN and either infinity give 0. Any other value is rounded, and its two's-complement form is reduced modulo 2^N for an N-bit destination.
- R5: With `src_dbl`=1 the operand is binary64 in `in_bits[63:0]`. With `src_dbl`=0 it is binary32 in `in_bits[31:0]`, and `in_bits[63:32]` has no effect.
- R6: With `dst_wide`=0 the destination is 32 bits. A signed result is sign-extended from bit 31 to 64 bits, and an unsigned result is zero-extended.
- R7: With `ov_en`=1, `out_ov`, `out_so` and `out_cr[0]` are 1 when the result differs from the input value (a fraction discarded by rounding, a clamped or wrapped value, a NaN or an infinity). Otherwise they are 0. With `ov_en`=0 they are 0.
- R8: With `rec_en`=1, `out_cr[3]`, `out_cr[2]` and `out_cr[1]` flag a result that is negative, positive or zero, read as a signed 64-bit number. With `rec_en`=0 these three bits are 0.
- R9: Mode codes 110 and 111 set `out_illegal`. They force `out_value`, `out_cr`, `out_ov` and `out_so` to 0.
- R10: A result appears one cycle after acceptance. While `out_valid`=1 and `out_ready`=0, the result is held and `in_ready`=0.
- R11: During and directly after reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_bits | input | 64 | Floating-point operand |
| src_dbl | input | 1 | 1: binary64 operand, 0: binary32 in low half |
| dst_wide | input | 1 | 1: 64-bit destination, 0: 32-bit |
| dst_sgn | input | 1 | 1: signed destination, 0: unsigned |
| mode | input | 3 | Policy and rounding-source selector |
| rnd | input | 2 | Dynamic rounding mode |
| rec_en | input | 1 | Produce sign/zero bits in the condition field |
| ov_en | input | 1 | Enable overflow reporting |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_value | output | 64 | Integer result |
| out_cr | output | 4 | {negative, positive, zero, summary overflow} |
| out_ov | output | 1 | Overflow flag |
| out_so | output | 1 | Summary-overflow flag |
| out_illegal | output | 1 | Mode code was not a legal one |

## Verification
The bench builds the unit with its default registered output stage. Every legal mode, every rounding mode, both operand formats and all four destination shapes are swept over quarter-step values from -3 to +3. This covers each tie, each rounding direction and the negative-to-unsigned clamp. The same cross product is run on signed operands placed just inside and outside 2^31, 2^32, 2^63 and 2^64, and beyond 2^64 for wrapping. It is also run on NaN and both infinities. Back-pressure is exercised by stalling the consumer while a second operation waits.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;
  localparam int XW     = 64;          // integer result width
  localparam int NW     = 32;          // narrow destination width
  localparam int MANTW  = 53;          // significand incl. hidden bit
  localparam int EXPW   = 13;          // unbiased exponent, signed
  localparam int PADW   = 2*XW - MANTW;
  localparam int SPADW  = MANTW - 24;  // binary32 fraction padding

  typedef enum logic [1:0] {RM_NEAR = 2'd0, RM_ZERO = 2'd1,
                            RM_UP = 2'd2, RM_DOWN = 2'd3} rnd_e;
  typedef enum logic [1:0] {POL_SAT_MIN = 2'd0, POL_SAT_ZERO = 2'd1,
                            POL_WRAP = 2'd2, POL_BAD = 2'd3} pol_e;

  typedef struct packed {
    logic                   sgn;
    logic                   is_nan;
    logic                   is_inf;
    logic signed [EXPW-1:0] exp;
    logic [MANTW-1:0]       mant;
  } unpk_t;

  typedef struct packed {
    logic [XW-1:0] value;
    logic [3:0]    cr;
    logic          ov;
    logic          illegal;
  } res_t;
endpackage

// File: rtl/fcvt_unpack.sv
module fcvt_unpack
  import fcvt_pkg::*;
(
  input  logic [XW-1:0] bits,
  input  logic          src_dbl,
  output unpk_t         u
);
  logic [10:0] de;
  logic [51:0] df;
  logic [7:0]  se;
  logic [22:0] sf;

  always_comb begin
    de = bits[62:52];
    df = bits[51:0];
    se = bits[30:23];
    sf = bits[22:0];
    u  = '0;
    if (src_dbl) begin
      u.sgn    = bits[63];
      u.is_inf = (&de) && (df == '0);
      u.is_nan = (&de) && (df != '0);
      u.exp    = (de == '0) ? -13'sd1022 : ($signed({2'b00, de}) - 13'sd1023);
      u.mant   = {(de != '0), df};
    end else begin
      u.sgn    = bits[31];
      u.is_inf = (&se) && (sf == '0);
      u.is_nan = (&se) && (sf != '0);
      u.exp    = (se == '0) ? -13'sd126 : ($signed({5'b00000, se}) - 13'sd127);
      u.mant   = {(se != '0), sf, {SPADW{1'b0}}};
    end
  end
endmodule

// File: rtl/fcvt_round.sv
module fcvt_round
  import fcvt_pkg::*;
(
  input  unpk_t       u,
  input  rnd_e        rm,
  output logic [XW:0] mag,      // rounded magnitude, may carry to 2^XW
  output logic        huge,     // magnitude is at least 2^XW before rounding
  output logic        inexact
);
  logic [2*XW-1:0] wide_w, shr, lost_mask;
  logic [XW-1:0]   intp;
  logic            g, s, inc;
  int              sh_r, sh_l;

  always_comb begin
    wide_w    = {u.mant, {PADW{1'b0}}};
    sh_r      = (XW - 1) - int'(u.exp);
    sh_l      = int'(u.exp) - (MANTW - 1);
    shr       = '0;
    lost_mask = '0;
    intp      = '0;
    g         = 1'b0;
    s         = 1'b0;
    huge      = 1'b0;
    if (u.exp >= 13'sd64) begin
      huge = 1'b1;
      intp = {{(XW-MANTW){1'b0}}, u.mant} << sh_l;
    end else if (u.exp >= -13'sd64) begin
      shr       = wide_w >> sh_r;
      lost_mask = ~({(2*XW){1'b1}} << sh_r);
      intp      = shr[2*XW-1:XW];
      g         = shr[XW-1];
      s         = (|shr[XW-2:0]) | (|(wide_w & lost_mask));
    end else begin
      s = |u.mant;
    end
    unique case (rm)
      RM_NEAR: inc = g & (s | intp[0]);
      RM_ZERO: inc = 1'b0;
      RM_UP:   inc = ~u.sgn & (g | s);
      default: inc = u.sgn & (g | s);
    endcase
    mag     = {1'b0, intp} + {{XW{1'b0}}, inc};
    inexact = g | s;
  end
endmodule

// File: rtl/fcvt_limit.sv
module fcvt_limit
  import fcvt_pkg::*;
(
  input  logic          sgn,
  input  logic          is_nan,
  input  logic          is_inf,
  input  logic [XW:0]   mag,
  input  logic          huge,
  input  logic          inexact,
  input  pol_e          pol,
  input  logic          dst_wide,
  input  logic          dst_sgn,
  output logic [XW-1:0] value,
  output logic          ovf
);
  logic [XW:0]   hi_mag, lo_mag;
  logic [XW-1:0] max_v, min_v, val, raw;
  logic          above, below;

  always_comb begin
    if (dst_sgn) begin
      hi_mag = dst_wide ? {2'b00, {(XW-1){1'b1}}} : {{(XW-NW+2){1'b0}}, {(NW-1){1'b1}}};
      lo_mag = dst_wide ? {2'b01, {(XW-1){1'b0}}} : {{(XW-NW+2){1'b0}}, 1'b1, {(NW-1){1'b0}}};
    end else begin
      hi_mag = dst_wide ? {1'b0, {XW{1'b1}}} : {{(XW-NW+1){1'b0}}, {NW{1'b1}}};
      lo_mag = '0;
    end
    max_v = hi_mag[XW-1:0];
    min_v = ~lo_mag[XW-1:0] + 1'b1;
    if (is_inf) begin
      above = ~sgn;
      below = sgn;
    end else begin
      above = ~is_nan & ~sgn & (huge | (mag > hi_mag));
      below = ~is_nan & sgn & (huge | (mag > lo_mag));
    end
    val = sgn ? (~mag[XW-1:0] + 1'b1) : mag[XW-1:0];
    unique case (pol)
      POL_SAT_MIN, POL_SAT_ZERO: begin
        if (is_nan)     raw = (pol == POL_SAT_MIN) ? min_v : '0;
        else if (above) raw = max_v;
        else if (below) raw = min_v;
        else            raw = val;
      end
      POL_WRAP: raw = (is_nan | is_inf) ? '0 : val;
      default:  raw = '0;
    endcase
    if (dst_wide)     value = raw;
    else if (dst_sgn) value = {{(XW-NW){raw[NW-1]}}, raw[NW-1:0]};
    else              value = {{(XW-NW){1'b0}}, raw[NW-1:0]};
    ovf = is_nan | is_inf | inexact | above | below;
  end
endmodule

// File: rtl/fcvt_int_unit.sv
module fcvt_int_unit
  import fcvt_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [XW-1:0] in_bits,
  input  logic          src_dbl,
  input  logic          dst_wide,
  input  logic          dst_sgn,
  input  logic [2:0]    mode,
  input  logic [1:0]    rnd,
  input  logic          rec_en,
  input  logic          ov_en,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [XW-1:0] out_value,
  output logic [3:0]    out_cr,
  output logic          out_ov,
  output logic          out_so,
  output logic          out_illegal
);
  unpk_t         u;
  rnd_e          rm;
  pol_e          pol;
  logic [XW:0]   mag;
  logic          huge, inexact, lim_ovf;
  logic [XW-1:0] lim_value;
  res_t          res_c, res_o;

  assign pol = pol_e'(mode[2:1]);
  assign rm  = mode[0] ? RM_ZERO : rnd_e'(rnd);

  fcvt_unpack u_unpack (.bits(in_bits), .src_dbl(src_dbl), .u(u));

  fcvt_round u_round (.u(u), .rm(rm), .mag(mag), .huge(huge), .inexact(inexact));

  fcvt_limit u_limit (
    .sgn(u.sgn), .is_nan(u.is_nan), .is_inf(u.is_inf), .mag(mag), .huge(huge),
    .inexact(inexact), .pol(pol), .dst_wide(dst_wide), .dst_sgn(dst_sgn),
    .value(lim_value), .ovf(lim_ovf)
  );

  always_comb begin
    res_c         = '0;
    res_c.illegal = (pol == POL_BAD);
    if (!res_c.illegal) begin
      res_c.value = lim_value;
      res_c.ov    = ov_en & lim_ovf;
      res_c.cr    = {rec_en && ($signed(lim_value) < 0),
                     rec_en && ($signed(lim_value) > 0),
                     rec_en && (lim_value == '0),
                     ov_en & lim_ovf};
    end
  end

  generate
    if (OUT_REG) begin : g_reg
      logic vld_q;
      res_t res_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q <= 1'b0;
          res_q <= '0;
        end else if (in_ready) begin
          vld_q <= in_valid;
          if (in_valid) res_q <= res_c;
        end
      end
      assign in_ready  = ~vld_q | out_ready;
      assign out_valid = vld_q;
      assign res_o     = res_q;
    end else begin : g_comb
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign res_o     = res_c;
    end
  endgenerate

  assign out_value   = res_o.value;
  assign out_cr      = res_o.cr;
  assign out_ov      = res_o.ov;
  assign out_so      = res_o.ov;
  assign out_illegal = res_o.illegal;
endmodule

// File: rtl/fcvt_int_unit_chk.sv
module fcvt_int_unit_chk #(
  parameter bit REG = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [63:0] out_value,
  input logic [3:0]  out_cr,
  input logic        out_ov,
  input logic        out_illegal
);
  p_illegal_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> out_value == '0 && out_cr == '0 && !out_ov);

  p_cr_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0(out_cr[3:1]));

  p_negative_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_cr[3] |-> out_value[63]);

  generate
    if (REG) begin : g_stream
      p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_value) && $stable(out_cr));
      p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);
    end
  endgenerate
endmodule

bind fcvt_int_unit fcvt_int_unit_chk #(.REG(OUT_REG)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_value(out_value), .out_cr(out_cr),
  .out_ov(out_ov), .out_illegal(out_illegal)
);

// File: tb/fcvt_int_unit_tb.sv
`timescale 1ns/1ps
module fcvt_int_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic [63:0] in_bits = '0;
  logic        src_dbl = 1'b1, dst_wide = 1'b1, dst_sgn = 1'b1;
  logic [2:0]  mode = '0;
  logic [1:0]  rnd = '0;
  logic        rec_en = 1'b0, ov_en = 1'b0;
  logic        out_valid, out_ready = 1'b0;
  logic [63:0] out_value;
  logic [3:0]  out_cr;
  logic        out_ov, out_so, out_illegal;
  int          n_chk = 0, n_bad = 0, op_cnt = 0;

  always #2.5 clk = ~clk;

  fcvt_int_unit u_dut (.*);

  function automatic logic [63:0] mk_dbl(input bit sg, input logic [127:0] q);
    int p;
    logic [127:0] t;
    int e;
    p = -1;
    for (int i = 0; i < 128; i++) if (q[i]) p = i;
    if (p < 0) return {sg, 63'b0};
    t = q << (127 - p);
    e = p - 2 + 1023;
    return {sg, e[10:0], t[126:75]};
  endfunction

  function automatic logic [31:0] mk_sgl(input logic [63:0] d, output bit ok);
    int e;
    ok = (d[28:0] == '0);
    if (d[62:0] == '0) return {d[63], 31'b0};
    e = int'(d[62:52]) - 1023 + 127;
    return {d[63], e[7:0], d[51:29]};
  endfunction

  // value is q/4 with sign sg
  function automatic void model(input bit sg, input logic [127:0] q, input bit inf, input bit nan,
                                input logic [2:0] md, input logic [1:0] rm, input bit wide,
                                input bit sgnd, output logic [63:0] ev, output bit eov);
    logic [127:0] m;
    bit g, s, inc;
    logic signed [131:0] v, hi, lo, r;
    logic [1:0] eff;
    int n;
    n   = wide ? 64 : 32;
    hi  = sgnd ? (132'sd1 <<< (n-1)) - 132'sd1 : (132'sd1 <<< n) - 132'sd1;
    lo  = sgnd ? -(132'sd1 <<< (n-1)) : 132'sd0;
    eff = md[0] ? 2'd1 : rm;
    m = q >> 2; g = q[1]; s = q[0];
    case (eff)
      2'd0: inc = g & (s | m[0]);
      2'd1: inc = 1'b0;
      2'd2: inc = !sg & (g | s);
      default: inc = sg & (g | s);
    endcase
    m = m + 128'(inc);
    v = sg ? -$signed({4'b0, m}) : $signed({4'b0, m});
    eov = nan || inf || g || s || (v > hi) || (v < lo);
    if (md[2])    r = (nan || inf) ? 132'sd0 : v;
    else if (nan) r = md[1] ? 132'sd0 : lo;
    else if (inf) r = sg ? lo : hi;
    else if (v > hi) r = hi;
    else if (v < lo) r = lo;
    else r = v;
    ev = wide ? r[63:0] : (sgnd ? {{32{r[31]}}, r[31:0]} : {32'b0, r[31:0]});
  endfunction

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %s expected %s", tag, act, exp);
    end
  endtask

  task automatic run(input logic [63:0] bits, input bit dbl, input logic [2:0] md,
                     input logic [1:0] rm, input bit wide, input bit sgnd, input bit rec,
                     input bit oen, input logic [63:0] ev, input bit eov, input bit eill,
                     input string tag);
    logic [3:0] ecr;
    bit eo;
    @(negedge clk);
    in_bits = bits; src_dbl = dbl; mode = md; rnd = rm; dst_wide = wide; dst_sgn = sgnd;
    rec_en = rec; ov_en = oen; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    eo  = eov && oen && !eill;
    ecr = eill ? 4'b0 : {rec && ($signed(ev) < 0), rec && ($signed(ev) > 0), rec && (ev == 0), eo};
    check(out_valid === 1'b1 && out_value === (eill ? 64'h0 : ev) && out_cr === ecr &&
          out_ov === eo && out_so === eo && out_illegal === eill, tag,
          $sformatf("v=%0b val=%h cr=%b ov=%b so=%b ill=%b", out_valid, out_value, out_cr, out_ov, out_so, out_illegal),
          $sformatf("v=1 val=%h cr=%b ov=%b so=%b ill=%b", eill ? 64'h0 : ev, ecr, eo, eo, eill));
  endtask

  task automatic do_case(input bit sg, input logic [127:0] q, input bit inf, input bit nan,
                         input bit dbl, input logic [2:0] md, input logic [1:0] rm,
                         input bit wide, input bit sgnd, input string base);
    logic [63:0] d, ev, bits;
    logic [31:0] sb;
    bit ok, eov, rec, oen;
    string tag;
    if (nan)      d = 64'h7FF8_0000_0000_0001;
    else if (inf) d = {sg, 63'h7FF0_0000_0000_0000};
    else          d = mk_dbl(sg, q);
    ok = 1'b1;
    if (nan)      sb = 32'h7FC0_0001;
    else if (inf) sb = {sg, 31'h7F80_0000};
    else          sb = mk_sgl(d, ok);
    if (!dbl && !ok) return;
    bits = dbl ? d : {32'hA5A5_5A5A, sb};
    op_cnt++;
    rec = (op_cnt % 3) != 0;
    oen = (op_cnt % 4) != 1;
    model(sg, q, inf, nan, md, rm, wide, sgnd, ev, eov);
    tag = base;
    if (!dbl)  tag = {tag, " R5"};
    if (!wide) tag = {tag, " R6"};
    if (oen)   tag = {tag, " R7"};
    if (rec)   tag = {tag, " R8"};
    run(bits, dbl, md, rm, wide, sgnd, rec, oen, ev, eov, 1'b0, tag);
  endtask

  function automatic logic [127:0] bq(input int i);
    logic [127:0] one;
    one = 128'd1;
    case (i)
      0: return (one << 31) << 2;
      1: return ((one << 31) - 1) << 2;
      2: return (((one << 31) - 1) << 2) + 2;
      3: return (one << 32) << 2;
      4: return (((one << 32) - 1) << 2) + 1;
      5: return (one << 63) << 2;
      6: return ((one << 63) - 1024) << 2;
      7: return (one << 64) << 2;
      8: return ((one << 64) - 2048) << 2;
      9: return (one << 70) << 2;
      10: return ((one << 70) + (one << 30)) << 2;
      11: return ((one << 31) << 2) + 2;
      default: return (((one << 32) - 1) << 2) + 2;
    endcase
  endfunction

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    logic [63:0] a_val;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0 && in_ready === 1'b1, "R11 in reset",
          $sformatf("valid=%b ready=%b", out_valid, in_ready), "valid=0 ready=1");
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0 && in_ready === 1'b1, "R11 after reset",
          $sformatf("valid=%b ready=%b", out_valid, in_ready), "valid=0 ready=1");

    // quarter-step sweep around zero: rounding and small-value policies
    for (int md = 0; md < 6; md++)
      for (int rm = 0; rm < 4; rm++)
        for (int dbl = 0; dbl < 2; dbl++)
          for (int cfg = 0; cfg < 4; cfg++)
            for (int k = -12; k <= 12; k++)
              do_case(k < 0, 128'(k < 0 ? -k : k), 1'b0, 1'b0, dbl[0], 3'(md), 2'(rm),
                      cfg[1], cfg[0], "R1 R2");

    // range limits of each destination
    for (int i = 0; i < 13; i++)
      for (int sg = 0; sg < 2; sg++)
        for (int md = 0; md < 6; md++)
          for (int rm = 0; rm < 4; rm++)
            for (int dbl = 0; dbl < 2; dbl++)
              for (int cfg = 0; cfg < 4; cfg++)
                do_case(sg[0], bq(i), 1'b0, 1'b0, dbl[0], 3'(md), 2'(rm), cfg[1], cfg[0], "R3 R4");

    // NaN and infinities
    for (int sp = 0; sp < 3; sp++)
      for (int md = 0; md < 6; md++)
        for (int rm = 0; rm < 4; rm++)
          for (int dbl = 0; dbl < 2; dbl++)
            for (int cfg = 0; cfg < 4; cfg++)
              do_case(sp == 2, 128'd0, sp != 0, sp == 0, dbl[0], 3'(md), 2'(rm),
                      cfg[1], cfg[0], "R1 R3 R4");

    // illegal codes
    for (int md = 6; md < 8; md++)
      for (int cfg = 0; cfg < 4; cfg++)
        run(64'h4004_0000_0000_0000, 1'b1, 3'(md), 2'(cfg), cfg[1], cfg[0], 1'b1, 1'b1,
            64'h0, 1'b1, 1'b1, "R9");

    // back-pressure: A = 2.5 -> 2, B = -7.0 -> -7
    @(negedge clk);
    out_ready = 1'b0;
    in_bits = 64'h4004_0000_0000_0000; src_dbl = 1'b1; mode = 3'b000; rnd = 2'b00;
    dst_wide = 1'b1; dst_sgn = 1'b1; rec_en = 1'b0; ov_en = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    a_val = 64'd2;
    in_bits = 64'hC01C_0000_0000_0000;
    check(out_valid === 1'b1 && out_value === a_val && in_ready === 1'b0, "R10 stall",
          $sformatf("valid=%b val=%h ready=%b", out_valid, out_value, in_ready),
          $sformatf("valid=1 val=%h ready=0", a_val));
    @(negedge clk);
    check(out_valid === 1'b1 && out_value === a_val, "R10 hold",
          $sformatf("valid=%b val=%h", out_valid, out_value), $sformatf("valid=1 val=%h", a_val));
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1 && out_value === 64'hFFFF_FFFF_FFFF_FFF9, "R10 drain and accept",
          $sformatf("valid=%b val=%h", out_valid, out_value), "valid=1 val=fffffffffffffff9");
    @(negedge clk);
    check(out_valid === 1'b0, "R10 empty", $sformatf("valid=%b", out_valid), "valid=0");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule